// File: doc/BRIEF.md
# Programmable Measurement Timing Sequencer

This block times the repeating measurement cycles of an optical sensing front end. A 1 µs enable pulse enters a programmable divider. Every divided pulse (the timebase step) advances an 8-bit cycle counter. Programmable on/off windows are compared against that counter to drive the LED, the two polarities of a synchronous demodulator and an integrator in lockstep. The block also issues a one-clock ADC start pulse at a programmed count and an end-of-cycle pulse for the interrupt logic.

The controller has two states, `SQ_IDLE` and `SQ_RUN`. There are three transitions:
- **start** (`SQ_IDLE`→`SQ_RUN`): taken when `run_en` is high and `cfg_per` is non-zero. It captures all configuration inputs and clears the counter.
- **wrap** (`SQ_RUN`→`SQ_RUN`): taken on the step that ends a cycle while the start condition still holds. It recaptures the configuration and restarts the count at 0.
- **halt** (`SQ_RUN`→`SQ_IDLE`): taken on that same final step when the start condition no longer holds.

One cycle lasts `cfg_per × (cfg_div + 1)` microseconds.

Top module: `meas_seq_top`

## Requirements
- R1: While `rst_n` is low, all six outputs are low, even with `run_en` high and a non-zero period applied.
- R2: In `SQ_RUN`, the counter advances once per `cfg_div+1` pulses of `tick_1us`. It runs from 0 to `cfg_per-1` and then wraps.
- R3: Each of `led_drv`, `demod_pos`, `demod_neg` and `integ_en` is high exactly while on ≤ count < off, using its own pair of inputs. When on ≥ off, that output stays low for the whole cycle.
- R4: `adc_go` is high for exactly one clock: the first clock in which the count equals `adc_at_t`. If `adc_at_t` ≥ `cfg_per`, it never pulses.
- R5: `seq_done` is high for exactly one clock after the final step of every cycle. That clock is the same clock in which the count shows 0 again, or in which the block shows idle.
- R6: With `cfg_per` = 0, the block stays in `SQ_IDLE` and all outputs stay low, even with `run_en` high.
- R7: The start transition makes the counter show 0 in the clock after `run_en` is first seen high.
- R8: If `run_en` is cleared in the middle of a cycle, that cycle still runs to its end. The block then takes halt, and its outputs stay low afterwards.
- R9: Configuration inputs are captured only by start and wrap. A change in mid-cycle first takes effect in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1us | input | 1 | One-clock enable pulse, once per microsecond |
| run_en | input | 1 | Keeps the sequencer cycling |
| cfg_div | input | 8 | Timebase divider; the step lasts value+1 pulses |
| cfg_per | input | 8 | Cycle length in steps; 0 keeps the block idle |
| led_on_t | input | 8 | Count at which the LED window opens |
| led_off_t | input | 8 | Count at which the LED window closes |
| dp_on_t | input | 8 | Count at which the positive demodulator phase opens |
| dp_off_t | input | 8 | Count at which the positive demodulator phase closes |
| dn_on_t | input | 8 | Count at which the negative demodulator phase opens |
| dn_off_t | input | 8 | Count at which the negative demodulator phase closes |
| int_on_t | input | 8 | Count at which the integrator starts |
| int_off_t | input | 8 | Count at which the integrator stops |
| adc_at_t | input | 8 | Count that triggers the ADC start |
| led_drv | output | 1 | LED drive window |
| demod_pos | output | 1 | Positive demodulator phase window |
| demod_neg | output | 1 | Negative demodulator phase window |
| integ_en | output | 1 | Integrator window |
| adc_go | output | 1 | One-clock ADC start pulse |
| seq_done | output | 1 | One-clock end-of-cycle pulse |

## Verification
A counter that runs wrong moves every window edge, and it also moves the ADC and end-of-cycle pulses. These errors appear at the very next timebase step, because all four windows are compared against that one counter. A divider fault stretches or shortens every step, so the step that brings the next expected output pattern comes early or late. A wrongly timed capture of the configuration shows as window edges in the rest of the current cycle that follow the new settings instead of the old ones. A halt that comes too early or too late shows as missing or extra windows at the end of the cycle. A wrong state is visible at the first clock of the next step, or at the latest at the next cycle boundary.

// File: rtl/meas_seq_pkg.sv
package meas_seq_pkg;

    parameter int SQ_W    = 8;
    parameter int NUM_WIN = 4;

    typedef enum logic [0:0] {
        SQ_IDLE = 1'b0,
        SQ_RUN  = 1'b1
    } sq_state_e;

    // configuration captured at each cycle boundary
    typedef struct packed {
        logic [SQ_W-1:0] div;
        logic [SQ_W-1:0] per;
        logic [SQ_W-1:0] adc_at;
        logic [NUM_WIN-1:0][SQ_W-1:0] on_t;
        logic [NUM_WIN-1:0][SQ_W-1:0] off_t;
    } seq_cfg_t;

endpackage

// File: rtl/seq_tick_div.sv
module seq_tick_div #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         tick,
    input  logic [W-1:0] div,
    output logic         step
);
    logic [W-1:0] dcnt;

    assign step = en && tick && (dcnt == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dcnt <= '0;
        end else if (!en) begin
            dcnt <= '0;
        end else if (tick) begin
            dcnt <= (dcnt == div) ? '0 : dcnt + W'(1);
        end
    end
endmodule

// File: rtl/seq_window.sv
module seq_window #(
    parameter int W = 8
) (
    input  logic         en,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] on_t,
    input  logic [W-1:0] off_t,
    output logic         act
);
    // half-open window; on >= off yields an empty window
    assign act = en && (cnt >= on_t) && (cnt < off_t);
endmodule

// File: rtl/meas_seq_top.sv
module meas_seq_top
    import meas_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_1us,
    input  logic            run_en,
    input  logic [SQ_W-1:0] cfg_div,
    input  logic [SQ_W-1:0] cfg_per,
    input  logic [SQ_W-1:0] led_on_t,
    input  logic [SQ_W-1:0] led_off_t,
    input  logic [SQ_W-1:0] dp_on_t,
    input  logic [SQ_W-1:0] dp_off_t,
    input  logic [SQ_W-1:0] dn_on_t,
    input  logic [SQ_W-1:0] dn_off_t,
    input  logic [SQ_W-1:0] int_on_t,
    input  logic [SQ_W-1:0] int_off_t,
    input  logic [SQ_W-1:0] adc_at_t,
    output logic            led_drv,
    output logic            demod_pos,
    output logic            demod_neg,
    output logic            integ_en,
    output logic            adc_go,
    output logic            seq_done
);
    localparam int WI_LED = 0;
    localparam int WI_POS = 1;
    localparam int WI_NEG = 2;
    localparam int WI_INT = 3;

    sq_state_e       st, st_nx;
    seq_cfg_t        cfg_q, cfg_in;
    logic [SQ_W-1:0] cnt;
    logic            running, step, last, start_ok, load;
    logic            cnt_new, done_q;
    logic [NUM_WIN-1:0] win;

    always_comb begin
        cfg_in.div            = cfg_div;
        cfg_in.per            = cfg_per;
        cfg_in.adc_at         = adc_at_t;
        cfg_in.on_t[WI_LED]   = led_on_t;
        cfg_in.off_t[WI_LED]  = led_off_t;
        cfg_in.on_t[WI_POS]   = dp_on_t;
        cfg_in.off_t[WI_POS]  = dp_off_t;
        cfg_in.on_t[WI_NEG]   = dn_on_t;
        cfg_in.off_t[WI_NEG]  = dn_off_t;
        cfg_in.on_t[WI_INT]   = int_on_t;
        cfg_in.off_t[WI_INT]  = int_off_t;
    end

    assign running  = (st == SQ_RUN);
    assign start_ok = run_en && (cfg_per != '0);
    assign last     = (cnt == cfg_q.per - SQ_W'(1));

    seq_tick_div #(.W(SQ_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (running),
        .tick  (tick_1us),
        .div   (cfg_q.div),
        .step  (step)
    );

    // next-state logic: start, wrap, halt
    always_comb begin
        st_nx = st;
        load  = 1'b0;
        unique case (st)
            SQ_IDLE: begin
                if (start_ok) begin
                    st_nx = SQ_RUN;
                    load  = 1'b1;
                end
            end
            SQ_RUN: begin
                if (step && last) begin
                    if (start_ok) begin
                        load = 1'b1;
                    end else begin
                        st_nx = SQ_IDLE;
                    end
                end
            end
            default: st_nx = SQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= SQ_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // counter, captured configuration and pulse flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            cfg_q   <= '0;
            cnt_new <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            if (load || (step && last)) begin
                cnt <= '0;
            end else if (step) begin
                cnt <= cnt + SQ_W'(1);
            end
            if (load) begin
                cfg_q <= cfg_in;
            end
            cnt_new <= load || step;
            done_q  <= running && step && last;
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_WIN; gi++) begin : g_win
            seq_window #(.W(SQ_W)) u_win (
                .en    (running),
                .cnt   (cnt),
                .on_t  (cfg_q.on_t[gi]),
                .off_t (cfg_q.off_t[gi]),
                .act   (win[gi])
            );
        end
    endgenerate

    // outputs
    always_comb begin
        led_drv   = win[WI_LED];
        demod_pos = win[WI_POS];
        demod_neg = win[WI_NEG];
        integ_en  = win[WI_INT];
        adc_go    = running && cnt_new && (cnt == cfg_q.adc_at);
        seq_done  = done_q;
    end
endmodule

// File: rtl/meas_seq_chk.sv
module meas_seq_chk
    import meas_seq_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            running,
    input logic            step,
    input logic [SQ_W-1:0] cnt,
    input seq_cfg_t        cfg_q,
    input logic            led_drv,
    input logic            demod_pos,
    input logic            demod_neg,
    input logic            integ_en,
    input logic            adc_go,
    input logic            seq_done
);
    // R2
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt < cfg_q.per));

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !step) |=> $stable(cnt));

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !step) |=> $stable(cfg_q));

    // R4
    adc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_go |=> !adc_go);

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done);

    // R5
    done_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> (cnt == '0));

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !(led_drv || demod_pos || demod_neg || integ_en || adc_go));
endmodule

bind meas_seq_top meas_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .running   (running),
    .step      (step),
    .cnt       (cnt),
    .cfg_q     (cfg_q),
    .led_drv   (led_drv),
    .demod_pos (demod_pos),
    .demod_neg (demod_neg),
    .integ_en  (integ_en),
    .adc_go    (adc_go),
    .seq_done  (seq_done)
);

// File: tb/tb_meas_seq_top.sv
module tb_meas_seq_top;

    typedef struct {
        int div, per, lon, loff, pon, poff, non, noff, ion, ioff, adc;
    } bcfg_t;

    typedef struct {
        bit    led, pos, neg, integ, adc, done;
        int    len;
        string tag;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_1us = 1'b0;
    logic run_en = 1'b0;
    logic [7:0] cfg_div = '0, cfg_per = '0;
    logic [7:0] led_on_t = '0, led_off_t = '0, dp_on_t = '0, dp_off_t = '0;
    logic [7:0] dn_on_t = '0, dn_off_t = '0, int_on_t = '0, int_off_t = '0, adc_at_t = '0;
    logic led_drv, demod_pos, demod_neg, integ_en, adc_go, seq_done;

    int total = 0;
    int bad = 0;
    item_t q[$];
    item_t last_it;
    bit start_pending = 0;
    bit tracking = 0;
    int tcnt = 0;
    int cur_len = 0;
    int phase = 0;

    always #10 clk = ~clk;

    meas_seq_top dut (
        .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .run_en(run_en),
        .cfg_div(cfg_div), .cfg_per(cfg_per),
        .led_on_t(led_on_t), .led_off_t(led_off_t),
        .dp_on_t(dp_on_t), .dp_off_t(dp_off_t),
        .dn_on_t(dn_on_t), .dn_off_t(dn_off_t),
        .int_on_t(int_on_t), .int_off_t(int_off_t), .adc_at_t(adc_at_t),
        .led_drv(led_drv), .demod_pos(demod_pos), .demod_neg(demod_neg),
        .integ_en(integ_en), .adc_go(adc_go), .seq_done(seq_done)
    );

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_quiet(string req);
        chk(req, "led_drv", led_drv, 0);
        chk(req, "demod_pos", demod_pos, 0);
        chk(req, "demod_neg", demod_neg, 0);
        chk(req, "integ_en", integ_en, 0);
        chk(req, "adc_go", adc_go, 0);
    endtask

    task automatic apply(bcfg_t c);
        cfg_div = 8'(c.div);   cfg_per = 8'(c.per);
        led_on_t = 8'(c.lon);  led_off_t = 8'(c.loff);
        dp_on_t = 8'(c.pon);   dp_off_t = 8'(c.poff);
        dn_on_t = 8'(c.non);   dn_off_t = 8'(c.noff);
        int_on_t = 8'(c.ion);  int_off_t = 8'(c.ioff);
        adc_at_t = 8'(c.adc);
    endtask

    function automatic item_t mk(bcfg_t c, int k, bit done, string tag);
        item_t it;
        it.led   = (k >= c.lon) && (k < c.loff);
        it.pos   = (k >= c.pon) && (k < c.poff);
        it.neg   = (k >= c.non) && (k < c.noff);
        it.integ = (k >= c.ion) && (k < c.ioff);
        it.adc   = (k == c.adc);
        it.done  = done;
        it.len   = c.div + 1;
        it.tag   = tag;
        return it;
    endfunction

    // driver: push expected steps, then run the DUT through them
    task automatic run_seq(bcfg_t a, int na, bcfg_t b, int nb);
        item_t st;
        int lastper;
        for (int k = 0; k < na; k++)
            for (int i = 0; i < a.per; i++)
                q.push_back(mk(a, i, (k > 0) && (i == 0),
                               (k == 0 && i == 0) ? "R7" : "R3"));
        for (int k = 0; k < nb; k++)
            for (int i = 0; i < b.per; i++)
                q.push_back(mk(b, i, i == 0, (k == 0) ? "R9" : "R3"));
        st = '{led:0, pos:0, neg:0, integ:0, adc:0, done:1, len:0, tag:"R8"};
        q.push_back(st);
        @(negedge clk);
        apply(a);
        run_en = 1'b1;
        @(posedge clk);
        #1 start_pending = 1'b1;
        if (nb > 0) begin
            while (q.size() > a.per + nb * b.per) @(negedge clk);
            @(negedge clk);
            apply(b);   // mid-cycle change, must wait for the boundary (R9)
        end
        lastper = (nb > 0) ? b.per : a.per;
        while (q.size() > lastper) @(negedge clk);
        @(negedge clk);
        run_en = 1'b0;  // mid-cycle clear (R8)
        while (q.size() > 0) @(negedge clk);
        repeat (12) begin
            @(negedge clk);
            chk_quiet("R8");
            chk("R8", "seq_done", seq_done, 0);
        end
    endtask

    // monitor and tick source
    always @(negedge clk) begin
        bit step;
        bit tick_prev;
        item_t it;
        tick_prev = tick_1us;
        step = 0;
        if (start_pending) begin
            step = 1;
            start_pending = 0;
        end else if (tracking && tick_prev) begin
            tcnt++;
            if (tcnt == cur_len) step = 1;
        end
        if (step) begin
            if (q.size() == 0) begin
                chk("R2", "unexpected step", 1, 0);
            end else begin
                it = q.pop_front();
                chk(it.tag, "led_drv", led_drv, it.led);
                chk(it.tag, "demod_pos", demod_pos, it.pos);
                chk(it.tag, "demod_neg", demod_neg, it.neg);
                chk(it.tag, "integ_en", integ_en, it.integ);
                chk("R4", "adc_go", adc_go, it.adc);
                chk("R5", "seq_done", seq_done, it.done);
                tcnt = 0;
                cur_len = it.len;
                tracking = (it.len != 0);
                last_it = it;
            end
        end else if (tracking) begin
            chk("R2", "led_drv hold", led_drv, last_it.led);
            chk("R2", "demod_pos hold", demod_pos, last_it.pos);
            chk("R2", "demod_neg hold", demod_neg, last_it.neg);
            chk("R2", "integ_en hold", integ_en, last_it.integ);
            chk("R4", "adc_go width", adc_go, 0);
            chk("R5", "seq_done width", seq_done, 0);
        end
        phase = (phase + 1) % 4;
        tick_1us = (phase == 0);
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bcfg_t ca, cb, cc, cd, ce;
        ca = '{div:1, per:6, lon:1, loff:4, pon:1, poff:3, non:3, noff:5, ion:0, ioff:5, adc:2};
        cb = '{div:0, per:4, lon:2, loff:2, pon:0, poff:4, non:3, noff:1, ion:1, ioff:3, adc:7};
        cc = '{div:2, per:1, lon:0, loff:1, pon:0, poff:0, non:0, noff:5, ion:1, ioff:2, adc:0};
        cd = '{div:255, per:2, lon:1, loff:2, pon:0, poff:1, non:1, noff:9, ion:0, ioff:2, adc:1};
        ce = '{div:0, per:255, lon:100, loff:254, pon:0, poff:128, non:128, noff:255, ion:3, ioff:250, adc:254};

        // R1: reset holds outputs low with a live configuration
        apply(ca);
        run_en = 1'b1;
        repeat (8) begin
            @(negedge clk);
            chk_quiet("R1");
            chk("R1", "seq_done", seq_done, 0);
        end
        run_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R6: zero period keeps the block idle
        apply(ca);
        cfg_per = 8'd0;
        run_en = 1'b1;
        repeat (60) begin
            @(negedge clk);
            chk_quiet("R6");
            chk("R6", "seq_done", seq_done, 0);
        end
        run_en = 1'b0;
        repeat (4) @(negedge clk);

        run_seq(ca, 2, cb, 2);   // windows, empty windows, capture at boundary
        run_seq(cc, 3, cc, 0);   // one-step cycle
        run_seq(cd, 1, cd, 0);   // largest divider
        run_seq(ce, 1, ce, 0);   // longest period

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule